// File: doc/BRIEF.md
# Button-Combination and Pin NMI Controller

This block raises non-maskable interrupts for an 8-bit CPU from two sources: an active-low external NMI pin, and a match between the live joypad state and a programmable button mask. When the CPU takes the request it jumps to a fixed vector. The block then holds the CPU in an NMI-handler state, in which ordinary interrupts stay blocked. The only way out of that state is a real return-from-interrupt instruction. An interrupt-enable instruction has no effect on it.

A request raised by the button combination also maps the boot ROM back into view, so the handler can run a menu from it. The boot ROM is taken out of view again by any opcode fetch of the return byte. A fetch counts when the byte is decoded as an opcode, and that includes the second byte of a prefixed pair. If a new request arrives while a handler is pending or running, one request is held back and raised after the handler returns. The CPU core sits outside this block. It tells the block when a byte is fetched as an opcode, when a return instruction completes, and when it takes the NMI.

Top module: `btn_nmi_ctrl`

## Requirements
- R1: After reset, nmi_req, nmi_active, user_irq_block and boot_remap are 0, the mask register reads 0x00, and nmi_vector shows 0x0080.
- R2: A write on reg_we loads reg_wdata into the mask register, and reg_rdata shows the mask two clock edges after the write edge. Mask and pad bit order is: bit7 Start, bit6 Select, bit5 B, bit4 A, bit3 Down, bit2 Up, bit1 Left, bit0 Right, with 1 meaning selected or pressed.
- R3: A mask of 0x00 never raises a request, whatever the pad state.
- R4: A request is raised when every bit set in the mask is pressed on pad_pressed. Extra pressed buttons do not prevent it, and a partial match raises nothing.
- R5: Both sources act on the edge of their assertion only. A button combination that is held, or a pin that is held low, gives a single request.
- R6: A falling edge on nmi_pin_n raises nmi_req within four clock edges and leaves boot_remap unchanged.
- R7: A request raised by the button combination sets boot_remap in the same edge that nmi_req rises.
- R8: When nmi_ack is high while nmi_req is high, the next edge clears nmi_req and sets nmi_active. user_irq_block is high while a request is pending or a handler is active.
- R9: While nmi_active is set, only reti_exec clears it. Opcode fetches, including a prefixed CB then D9 pair, leave it set.
- R10: One request that arrives while a request is pending or a handler is active is buffered, and nmi_req is raised on the edge at which reti_exec ends the handler. Any further requests in that window are dropped.
- R11: An op_fetch strobe with op_byte equal to 0xD9 clears boot_remap. Other fetched bytes, and a 0xD9 on op_byte without the strobe, leave it unchanged. reti_exec alone does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the mask register |
| reg_wdata | input | 8 | Mask write data |
| reg_rdata | output | 8 | Mask read data (registered) |
| pad_pressed | input | 8 | Joypad state, 1 = pressed, asynchronous |
| nmi_pin_n | input | 1 | External NMI pin, active low, asynchronous |
| op_fetch | input | 1 | A byte is being decoded as an opcode |
| op_byte | input | 8 | Byte being fetched |
| reti_exec | input | 1 | A return-from-interrupt instruction completed |
| nmi_ack | input | 1 | The CPU takes the NMI |
| nmi_req | output | 1 | NMI request to the CPU |
| nmi_vector | output | 16 | NMI vector address |
| nmi_active | output | 1 | An NMI handler is running |
| user_irq_block | output | 1 | Ordinary interrupts must be held off |
| boot_remap | output | 1 | Boot ROM is mapped into view |

## Verification
Most faults in this block appear at the ports one edge after a CPU strobe, because the handler flag, the pending request and the remap flag are the state the CPU sees directly. If the buffer slot is lost, there is no nmi_req on the edge after reti_exec. If the slot is not cleared, a second nmi_req appears after a later return. A bad edge detector shows up as repeat requests while a button combination is held. The bench checks the request, handler, block and remap outputs after every strobe, so each of these faults is caught within one or two cycles of the event that exposes it.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
  localparam int unsigned PAD_W   = 8;
  localparam int unsigned ADDR_W  = 16;
  localparam logic [15:0] NMI_VEC = 16'h0080;
  localparam logic [7:0]  RET_OPC = 8'hD9;

  // Pad bit order: upper nibble buttons, lower nibble directions.
  localparam int unsigned PB_RIGHT  = 0;
  localparam int unsigned PB_LEFT   = 1;
  localparam int unsigned PB_UP     = 2;
  localparam int unsigned PB_DOWN   = 3;
  localparam int unsigned PB_A      = 4;
  localparam int unsigned PB_B      = 5;
  localparam int unsigned PB_SELECT = 6;
  localparam int unsigned PB_START  = 7;

  typedef enum logic {
    SRC_PIN = 1'b0,
    SRC_PAD = 1'b1
  } nmi_src_e;
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= RST_VAL;
    else     stage[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[i] <= RST_VAL;
      else     stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/nmi_pin_edge.sv
module nmi_pin_edge (
  input  logic clk,
  input  logic rst,
  input  logic pin_n_sync,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= pin_n_sync;
  end

  assign fall = prev_q & ~pin_n_sync;

  // R5: a held-low pin yields a single pulse
  a_r5_pin_one_pulse: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/nmi_pad_match.sv
module nmi_pad_match #(
  parameter int unsigned PAD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PAD_W-1:0] pad_sync,
  input  logic [PAD_W-1:0] mask,
  output logic             hit
);
  logic match, match_q;

  always_comb begin
    match = |mask;
    for (int i = 0; i < PAD_W; i++)
      if (mask[i] && !pad_sync[i]) match = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) match_q <= 1'b0;
    else     match_q <= match;
  end

  assign hit = match & ~match_q;

  // R3: an empty mask never produces a hit
  a_r3_zero_mask_silent: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |-> !hit);
  // R5: a held combination gives one hit
  a_r5_pad_one_pulse: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);
endmodule

// File: rtl/nmi_seq.sv
module nmi_seq
  import nmi_pkg::*;
#(
  parameter int unsigned OPC_W = 8,
  parameter logic [OPC_W-1:0] RET_BYTE = RET_OPC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_trig,
  input  logic             pad_trig,
  input  logic             op_fetch,
  input  logic [OPC_W-1:0] op_byte,
  input  logic             reti_exec,
  input  logic             nmi_ack,
  output logic             nmi_req,
  output logic             nmi_active,
  output logic             irq_block,
  output logic             boot_remap
);
  logic     req_q, act_q, pend_q, blk_q, remap_q;
  nmi_src_e pend_src_q;

  logic     req_n, act_n, pend_n;
  nmi_src_e pend_src_n;
  logic     raise;
  nmi_src_e raise_src;
  logic     trig;
  nmi_src_e trig_src;
  logic     remap_set, remap_clr, remap_n;

  assign trig     = pin_trig | pad_trig;
  assign trig_src = pad_trig ? SRC_PAD : SRC_PIN;

  always_comb begin
    req_n      = req_q;
    act_n      = act_q;
    pend_n     = pend_q;
    pend_src_n = pend_src_q;
    raise      = 1'b0;
    raise_src  = SRC_PIN;

    if (nmi_ack && req_q) begin
      req_n = 1'b0;
      act_n = 1'b1;
    end

    if (reti_exec && act_q) begin
      act_n = 1'b0;
      if (pend_q) begin
        req_n     = 1'b1;
        pend_n    = 1'b0;
        raise     = 1'b1;
        raise_src = pend_src_q;
      end
    end

    if (trig) begin
      if (!req_n && !act_n) begin
        req_n     = 1'b1;
        raise     = 1'b1;
        raise_src = trig_src;
      end else if (!pend_n) begin
        pend_n     = 1'b1;
        pend_src_n = trig_src;
      end
    end
  end

  assign remap_set = raise && (raise_src == SRC_PAD);
  assign remap_clr = op_fetch && (op_byte == RET_BYTE);

  always_comb begin
    remap_n = remap_q;
    if (remap_clr) remap_n = 1'b0;
    if (remap_set) remap_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q      <= 1'b0;
      act_q      <= 1'b0;
      pend_q     <= 1'b0;
      pend_src_q <= SRC_PIN;
      blk_q      <= 1'b0;
      remap_q    <= 1'b0;
    end else begin
      req_q      <= req_n;
      act_q      <= act_n;
      pend_q     <= pend_n;
      pend_src_q <= pend_src_n;
      blk_q      <= req_n | act_n;
      remap_q    <= remap_n;
    end
  end

  assign nmi_req    = req_q;
  assign nmi_active = act_q;
  assign irq_block  = blk_q;
  assign boot_remap = remap_q;

  // R8: acknowledge moves the request into the handler state
  a_r8_ack_enters: assert property (@(posedge clk) disable iff (rst)
    (nmi_ack && req_q) |=> (act_q && !req_q));
  // R8: a request and a running handler never coexist
  a_r8_req_excl_active: assert property (@(posedge clk) disable iff (rst)
    !(req_q && act_q));
  // R9: only a return ends the handler
  a_r9_hold_active: assert property (@(posedge clk) disable iff (rst)
    (act_q && !reti_exec) |=> act_q);
  // R10: a buffered request is raised on the return edge
  a_r10_pending_raised: assert property (@(posedge clk) disable iff (rst)
    (act_q && reti_exec && pend_q) |=> req_q);
  // R11: return-byte fetch unmaps unless a pad request rises together
  a_r11_unmap: assert property (@(posedge clk) disable iff (rst)
    (remap_clr && !remap_set) |=> !remap_q);
endmodule

// File: rtl/btn_nmi_ctrl.sv
module btn_nmi_ctrl
  import nmi_pkg::*;
#(
  parameter int unsigned PAD_BITS    = PAD_W,
  parameter int unsigned SYNC_DEPTH  = 2,
  parameter int unsigned VEC_W       = ADDR_W,
  parameter logic [VEC_W-1:0] VECTOR = NMI_VEC
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_we,
  input  logic [PAD_BITS-1:0] reg_wdata,
  output logic [PAD_BITS-1:0] reg_rdata,
  input  logic [PAD_BITS-1:0] pad_pressed,
  input  logic                nmi_pin_n,
  input  logic                op_fetch,
  input  logic [7:0]          op_byte,
  input  logic                reti_exec,
  input  logic                nmi_ack,
  output logic                nmi_req,
  output logic [VEC_W-1:0]    nmi_vector,
  output logic                nmi_active,
  output logic                user_irq_block,
  output logic                boot_remap
);
  logic [PAD_BITS-1:0] mask_q, rdata_q, pad_s;
  logic                pin_s, pin_fall, pad_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (reg_we) mask_q <= reg_wdata;
      rdata_q <= mask_q;
    end
  end

  assign reg_rdata  = rdata_q;
  assign nmi_vector = VECTOR;

  nmi_sync #(.WIDTH(PAD_BITS), .STAGES(SYNC_DEPTH), .RST_VAL('0)) u_pad_sync (
    .clk(clk), .rst(rst), .d(pad_pressed), .q(pad_s));

  nmi_sync #(.WIDTH(1), .STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst(rst), .d(nmi_pin_n), .q(pin_s));

  nmi_pin_edge u_pin_edge (
    .clk(clk), .rst(rst), .pin_n_sync(pin_s), .fall(pin_fall));

  nmi_pad_match #(.PAD_W(PAD_BITS)) u_pad_match (
    .clk(clk), .rst(rst), .pad_sync(pad_s), .mask(mask_q), .hit(pad_hit));

  nmi_seq u_seq (
    .clk(clk), .rst(rst),
    .pin_trig(pin_fall), .pad_trig(pad_hit),
    .op_fetch(op_fetch), .op_byte(op_byte),
    .reti_exec(reti_exec), .nmi_ack(nmi_ack),
    .nmi_req(nmi_req), .nmi_active(nmi_active),
    .irq_block(user_irq_block), .boot_remap(boot_remap));

  // R2: the register read port follows the written mask
  a_r2_readback: assert property (@(posedge clk) disable iff (rst)
    $past(reg_we) |=> (reg_rdata == $past(reg_wdata, 2)));
  // R1: the vector never moves
  a_r1_vector_fixed: assert property (@(posedge clk) disable iff (rst)
    nmi_vector == 16'h0080);
endmodule

// File: tb/btn_nmi_ctrl_bench.sv
module btn_nmi_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] pad_pressed = '0;
  logic       nmi_pin_n = 1'b1;
  logic       op_fetch = 1'b0;
  logic [7:0] op_byte = '0;
  logic       reti_exec = 1'b0;
  logic       nmi_ack = 1'b0;
  logic       nmi_req, nmi_active, user_irq_block, boot_remap;
  logic [15:0] nmi_vector;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    string tag;
    logic  req, act, blk, remap;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  btn_nmi_ctrl u_btn_nmi_ctrl (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pad_pressed(pad_pressed), .nmi_pin_n(nmi_pin_n),
    .op_fetch(op_fetch), .op_byte(op_byte), .reti_exec(reti_exec),
    .nmi_ack(nmi_ack), .nmi_req(nmi_req), .nmi_vector(nmi_vector),
    .nmi_active(nmi_active), .user_irq_block(user_irq_block),
    .boot_remap(boot_remap));

  // Monitor: compares port state with the next scoreboard item at negedge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      logic [3:0] got, want;
      e    = sb_q.pop_front();
      got  = {nmi_req, nmi_active, user_irq_block, boot_remap};
      want = {e.req, e.act, e.blk, e.remap};
      checks++;
      if (got !== want) begin
        fails++;
        $display("FAIL %s: req/act/blk/remap got %b expected %b", e.tag, got, want);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_st(input string tag, input logic r, input logic a,
                           input logic b, input logic m);
    exp_t e;
    e.tag = tag; e.req = r; e.act = a; e.blk = b; e.remap = m;
    sb_q.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic check_val(input string tag, input logic [15:0] got,
                           input logic [15:0] want);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, want);
    end
  endtask

  task automatic pulse_ack();    nmi_ack = 1'b1;   step(1); nmi_ack = 1'b0;   endtask
  task automatic pulse_reti();   reti_exec = 1'b1; step(1); reti_exec = 1'b0; endtask
  task automatic fetch(input logic [7:0] b);
    op_fetch = 1'b1; op_byte = b; step(1); op_fetch = 1'b0;
  endtask
  task automatic pin_pulse();
    nmi_pin_n = 1'b0; step(4); nmi_pin_n = 1'b1; step(4);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    expect_st("R1 reset outputs", 0, 0, 0, 0);
    check_val("R1 mask reset", {8'h00, reg_rdata}, 16'h0000);
    check_val("R1 vector", nmi_vector, 16'h0080);

    // R3 empty mask with all buttons pressed
    pad_pressed = 8'hFF; step(6);
    expect_st("R3 zero mask no request", 0, 0, 0, 0);
    pad_pressed = 8'h00; step(4);

    // R2 write Start+Right mask and read back
    reg_wdata = 8'h81; reg_we = 1'b1; step(1); reg_we = 1'b0;
    step(1);
    check_val("R2 mask readback", {8'h00, reg_rdata}, 16'h0081);

    // R4 partial match: Start only
    pad_pressed = 8'h80; step(6);
    expect_st("R4 partial match silent", 0, 0, 0, 0);
    // R4/R7 full match with extra A pressed
    pad_pressed = 8'h91; step(4);
    expect_st("R4 R7 full match raises with remap", 1, 0, 1, 1);

    // R8 acknowledge
    pulse_ack();
    expect_st("R8 ack enters handler", 0, 1, 1, 1);
    step(8);
    expect_st("R5 held combination no repeat", 0, 1, 1, 1);
    // R11 non-return opcode keeps remap
    fetch(8'h3E);
    op_byte = 8'hD9; step(1);
    expect_st("R11 non-D9 fetch and bare operand keep remap", 0, 1, 1, 1);
    // R9 prefixed CB D9: unmaps, stays in handler
    fetch(8'hCB);
    fetch(8'hD9);
    expect_st("R9 R11 CB D9 unmaps, handler stays", 0, 1, 1, 0);
    pulse_reti();
    expect_st("R9 return leaves handler", 0, 0, 0, 0);
    step(6);
    expect_st("R5 held combination after return", 0, 0, 0, 0);
    pad_pressed = 8'h00; step(4);

    // R6 pin request, held low
    nmi_pin_n = 1'b0; step(4);
    expect_st("R6 pin request, no remap", 1, 0, 1, 0);
    step(6);
    expect_st("R5 held pin single request", 1, 0, 1, 0);
    pulse_ack();
    nmi_pin_n = 1'b1; step(4);
    expect_st("R8 pin handler active", 0, 1, 1, 0);
    // R10 two more pulses in handler: one buffered, one dropped
    pin_pulse();
    pin_pulse();
    expect_st("R10 pulses held during handler", 0, 1, 1, 0);
    pulse_reti();
    expect_st("R10 buffered request on return", 1, 0, 1, 0);
    pulse_ack();
    pulse_reti();
    step(4);
    expect_st("R10 extra pulse dropped", 0, 0, 0, 0);

    // R11 return without D9 fetch keeps remap; D9 fetch outside handler clears
    pad_pressed = 8'h81; step(4);
    expect_st("R7 second pad request remaps", 1, 0, 1, 1);
    pulse_ack();
    pulse_reti();
    expect_st("R11 reti strobe alone keeps remap", 0, 0, 0, 1);
    fetch(8'hD9);
    expect_st("R11 D9 fetch clears remap", 0, 0, 0, 0);
    pad_pressed = 8'h00; step(4);

    // R3 clear mask to zero: pressing everything raises nothing
    reg_wdata = 8'h00; reg_we = 1'b1; step(1); reg_we = 1'b0;
    pad_pressed = 8'hFF; step(6);
    expect_st("R3 cleared mask silent", 0, 0, 0, 0);
    check_val("R2 cleared mask readback", {8'h00, reg_rdata}, 16'h0000);

    step(2);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule